// File: doc/BRIEF.md
# Radix-2 DIF Butterfly with Three-Multiplier Twiddle Product

This block performs one decimation-in-frequency radix-2 butterfly on complex signed fixed-point samples. Each accepted sample carries two complex operands A and B and a complex twiddle W. The upper leg returns the exact sum A + B. The lower leg returns the difference A − B rotated by W. An N-point transform uses log2(N) stages of N/2 such butterflies. Sequencing of those stages, twiddle storage and output reordering are left to the surrounding datapath.

The twiddle rotation uses three real multipliers instead of four. The difference d = dr + j·di is the first factor and W = wr + j·wi is the second. One cross term, di·(wr − wi), is formed once and added to both halves of the result: real = wr·(dr − di) + di·(wr − wi) and imag = wi·(dr + di) + di·(wr − wi). The two pre-adders sit in front of the multipliers. The datapath is cut into a pre-add stage, a multiply stage and a post-add stage. A valid flag travels alongside the data, and one new sample can enter every cycle.

The twiddle is a signed word of TW bits with TF fraction bits, so unity is 2^TF. Sums and differences grow by one bit. The rotated result is rounded half-up and scaled down by TF bits. The D outputs are wide enough that no input combination can overflow them.

Top module: `bfly_dif3m`

## Requirements
- R1: While rst_ni is low, and at the first sample point after it is released, valid_o is 0 and every data output is 0.
- R2: valid_o equals valid_i delayed by exactly three rising clock edges, so a sample presented before edge k appears after edge k+3.
- R3: For each valid sample, c_re_o = a_re_i + b_re_i and c_im_o = a_im_i + b_im_i, exact in DW+1 signed bits.
- R4: For each valid sample, d_re_o = floor((Pr + 2^(TF−1)) / 2^TF) and d_im_o = floor((Pi + 2^(TF−1)) / 2^TF). Here Pr = dr·wr − di·wi and Pi = dr·wi + di·wr, with dr = a_re_i − b_re_i and di = a_im_i − b_im_i. This is round half toward plus infinity.
- R5: With w_re_i = 2^TF and w_im_i = 0, d_re_o equals a_re_i − b_re_i and d_im_o equals a_im_i − b_im_i exactly.
- R6: Full-scale operands, including the most negative values of A, B and W, produce the exact R4 result with no wrap. D is DW+TW+3−TF bits wide.
- R7: When valid_o is low, all four data outputs keep the values of the last valid sample. Input data presented with valid_i low has no effect on them.
- R8: Samples presented on consecutive cycles are each processed independently, at a throughput of one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| a_re_i | input | DW | Operand A, real part |
| a_im_i | input | DW | Operand A, imaginary part |
| b_re_i | input | DW | Operand B, real part |
| b_im_i | input | DW | Operand B, imaginary part |
| w_re_i | input | TW | Twiddle, real part, TF fraction bits |
| w_im_i | input | TW | Twiddle, imaginary part, TF fraction bits |
| valid_o | output | 1 | Output sample qualifier |
| c_re_o | output | DW+1 | Upper leg A+B, real |
| c_im_o | output | DW+1 | Upper leg A+B, imaginary |
| d_re_o | output | DW+TW+3−TF | Lower leg (A−B)·W, real |
| d_im_o | output | DW+TW+3−TF | Lower leg (A−B)·W, imaginary |

## Verification
Two things can happen in the same cycle: a new sample is loaded into the pre-add stage while an older one is leaving the post-add stage, or a bubble enters while held outputs must stay frozen. The bench provokes both cases with valid_i driven randomly high for about three cycles in four and with back-to-back bursts. During bubbles it puts random data on the inputs. Every cycle's outputs are compared against a reference model that uses four multipliers and is delayed by three cycles. Bubble cycles are expected to repeat the last valid result.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  localparam int unsigned BFLY_LATENCY = 3;

  // width of the rounded rotated leg: full product growth minus fraction bits
  function automatic int dout_width(input int dw, input int tw, input int tf);
    return dw + tw + 3 - tf;
  endfunction

  function automatic int prod_width(input int dw, input int tw);
    return dw + tw + 2;
  endfunction

endpackage

// File: rtl/bfly_preadd.sv
module bfly_preadd #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic signed [TW-1:0] w_re_i,
  input  logic signed [TW-1:0] w_im_i,
  output logic                 valid_o,
  output logic signed [DW:0]   c_re_o,
  output logic signed [DW:0]   c_im_o,
  output logic signed [DW+1:0] sa_o,
  output logic signed [DW+1:0] sb_o,
  output logic signed [DW:0]   di_o,
  output logic signed [TW:0]   sw_o,
  output logic signed [TW-1:0] wr_o,
  output logic signed [TW-1:0] wi_o
);
  localparam int DW1 = DW + 1;
  localparam int DW2 = DW + 2;
  localparam int TW1 = TW + 1;

  logic signed [DW:0]   sum_re, sum_im, dif_re, dif_im;
  logic signed [DW+1:0] sa_c, sb_c;
  logic signed [TW:0]   sw_c;

  always_comb begin
    sum_re = DW1'(a_re_i) + DW1'(b_re_i);
    sum_im = DW1'(a_im_i) + DW1'(b_im_i);
    dif_re = DW1'(a_re_i) - DW1'(b_re_i);
    dif_im = DW1'(a_im_i) - DW1'(b_im_i);
    // operands feeding the three real multipliers
    sa_c   = DW2'(dif_re) - DW2'(dif_im);
    sb_c   = DW2'(dif_re) + DW2'(dif_im);
    sw_c   = TW1'(w_re_i) - TW1'(w_im_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      c_re_o  <= '0;
      c_im_o  <= '0;
      sa_o    <= '0;
      sb_o    <= '0;
      di_o    <= '0;
      sw_o    <= '0;
      wr_o    <= '0;
      wi_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        c_re_o <= sum_re;
        c_im_o <= sum_im;
        sa_o   <= sa_c;
        sb_o   <= sb_c;
        di_o   <= dif_im;
        sw_o   <= sw_c;
        wr_o   <= w_re_i;
        wi_o   <= w_im_i;
      end
    end
  end

  // R2
  a_r2_pre_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  a_r7_pre_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sa_o) && $stable(sb_o) && $stable(di_o) && $stable(c_re_o) && $stable(c_im_o)));

endmodule

// File: rtl/bfly_mult.sv
module bfly_mult #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW:0]   c_re_i,
  input  logic signed [DW:0]   c_im_i,
  input  logic signed [DW+1:0] sa_i,
  input  logic signed [DW+1:0] sb_i,
  input  logic signed [DW:0]   di_i,
  input  logic signed [TW:0]   sw_i,
  input  logic signed [TW-1:0] wr_i,
  input  logic signed [TW-1:0] wi_i,
  output logic                 valid_o,
  output logic signed [DW:0]   c_re_o,
  output logic signed [DW:0]   c_im_o,
  output logic signed [bfly_pkg::prod_width(DW, TW)-1:0] m_re_o,
  output logic signed [bfly_pkg::prod_width(DW, TW)-1:0] m_im_o,
  output logic signed [bfly_pkg::prod_width(DW, TW)-1:0] m_x_o
);
  localparam int PW = bfly_pkg::prod_width(DW, TW);

  logic signed [PW-1:0] p_re, p_im, p_x;

  always_comb begin
    p_re = PW'(wr_i) * PW'(sa_i);   // wr*(dr-di)
    p_im = PW'(wi_i) * PW'(sb_i);   // wi*(dr+di)
    p_x  = PW'(di_i) * PW'(sw_i);   // shared cross term di*(wr-wi)
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      c_re_o  <= '0;
      c_im_o  <= '0;
      m_re_o  <= '0;
      m_im_o  <= '0;
      m_x_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        c_re_o <= c_re_i;
        c_im_o <= c_im_i;
        m_re_o <= p_re;
        m_im_o <= p_im;
        m_x_o  <= p_x;
      end
    end
  end

  // R2
  a_r2_mul_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  a_r7_mul_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(m_re_o) && $stable(m_im_o) && $stable(m_x_o)));

endmodule

// File: rtl/bfly_postadd.sv
module bfly_postadd #(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int TF = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW:0]   c_re_i,
  input  logic signed [DW:0]   c_im_i,
  input  logic signed [bfly_pkg::prod_width(DW, TW)-1:0] m_re_i,
  input  logic signed [bfly_pkg::prod_width(DW, TW)-1:0] m_im_i,
  input  logic signed [bfly_pkg::prod_width(DW, TW)-1:0] m_x_i,
  output logic                 valid_o,
  output logic signed [DW:0]   c_re_o,
  output logic signed [DW:0]   c_im_o,
  output logic signed [bfly_pkg::dout_width(DW, TW, TF)-1:0] d_re_o,
  output logic signed [bfly_pkg::dout_width(DW, TW, TF)-1:0] d_im_o
);
  localparam int PW  = bfly_pkg::prod_width(DW, TW);
  localparam int PRW = PW + 1;
  localparam logic signed [PRW-1:0] HALF = {{(PRW-1){1'b0}}, 1'b1} << (TF - 1);

  logic signed [PRW-1:0] re_sum, im_sum, re_rnd, im_rnd;

  always_comb begin
    re_sum = PRW'(m_re_i) + PRW'(m_x_i);
    im_sum = PRW'(m_im_i) + PRW'(m_x_i);
    re_rnd = re_sum + HALF;
    im_rnd = im_sum + HALF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      c_re_o  <= '0;
      c_im_o  <= '0;
      d_re_o  <= '0;
      d_im_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        c_re_o <= c_re_i;
        c_im_o <= c_im_i;
        d_re_o <= re_rnd[PRW-1:TF];
        d_im_o <= im_rnd[PRW-1:TF];
      end
    end
  end

  // R2
  a_r2_out_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R7
  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(d_re_o) && $stable(d_im_o) && $stable(c_re_o) && $stable(c_im_o)));

endmodule

// File: rtl/bfly_dif3m.sv
module bfly_dif3m #(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int TF = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic signed [TW-1:0] w_re_i,
  input  logic signed [TW-1:0] w_im_i,
  output logic                 valid_o,
  output logic signed [DW:0]   c_re_o,
  output logic signed [DW:0]   c_im_o,
  output logic signed [bfly_pkg::dout_width(DW, TW, TF)-1:0] d_re_o,
  output logic signed [bfly_pkg::dout_width(DW, TW, TF)-1:0] d_im_o
);
  localparam int PW  = bfly_pkg::prod_width(DW, TW);
  localparam int DOW = bfly_pkg::dout_width(DW, TW, TF);

  logic                 s1_v, s2_v;
  logic signed [DW:0]   s1_c_re, s1_c_im, s2_c_re, s2_c_im, s1_di;
  logic signed [DW+1:0] s1_sa, s1_sb;
  logic signed [TW:0]   s1_sw;
  logic signed [TW-1:0] s1_wr, s1_wi;
  logic signed [PW-1:0] s2_m_re, s2_m_im, s2_m_x;

  bfly_preadd #(.DW(DW), .TW(TW)) i_preadd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .a_re_i (a_re_i),
    .a_im_i (a_im_i),
    .b_re_i (b_re_i),
    .b_im_i (b_im_i),
    .w_re_i (w_re_i),
    .w_im_i (w_im_i),
    .valid_o(s1_v),
    .c_re_o (s1_c_re),
    .c_im_o (s1_c_im),
    .sa_o   (s1_sa),
    .sb_o   (s1_sb),
    .di_o   (s1_di),
    .sw_o   (s1_sw),
    .wr_o   (s1_wr),
    .wi_o   (s1_wi)
  );

  bfly_mult #(.DW(DW), .TW(TW)) i_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s1_v),
    .c_re_i (s1_c_re),
    .c_im_i (s1_c_im),
    .sa_i   (s1_sa),
    .sb_i   (s1_sb),
    .di_i   (s1_di),
    .sw_i   (s1_sw),
    .wr_i   (s1_wr),
    .wi_i   (s1_wi),
    .valid_o(s2_v),
    .c_re_o (s2_c_re),
    .c_im_o (s2_c_im),
    .m_re_o (s2_m_re),
    .m_im_o (s2_m_im),
    .m_x_o  (s2_m_x)
  );

  bfly_postadd #(.DW(DW), .TW(TW), .TF(TF)) i_postadd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s2_v),
    .c_re_i (s2_c_re),
    .c_im_i (s2_c_im),
    .m_re_i (s2_m_re),
    .m_im_i (s2_m_im),
    .m_x_i  (s2_m_x),
    .valid_o(valid_o),
    .c_re_o (c_re_o),
    .c_im_o (c_im_o),
    .d_re_o (d_re_o),
    .d_im_o (d_im_o)
  );

  // observation terms for the unity-twiddle check
  localparam logic signed [TW-1:0] UNITY = {{(TW-1){1'b0}}, 1'b1} << TF;
  logic                  unity_in;
  logic signed [DOW-1:0] dif_re_in, dif_im_in;
  assign unity_in  = valid_i && (w_re_i == UNITY) && (w_im_i == '0);
  assign dif_re_in = DOW'(a_re_i) - DOW'(b_re_i);
  assign dif_im_in = DOW'(a_im_i) - DOW'(b_im_i);

  // R5
  a_r5_unity_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(unity_in, 3)) |-> (d_re_o == $past(dif_re_in, 3) && d_im_o == $past(dif_im_in, 3)));

endmodule

// File: tb/test_bfly_dif3m.sv
module test_bfly_dif3m;
  localparam int DW  = 16;
  localparam int TW  = 16;
  localparam int TF  = 14;
  localparam int DOW = DW + TW + 3 - TF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic                  valid_i = 1'b0;
  logic signed [DW-1:0]  a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic signed [TW-1:0]  w_re_i = '0, w_im_i = '0;
  logic                  valid_o;
  logic signed [DW:0]    c_re_o, c_im_o;
  logic signed [DOW-1:0] d_re_o, d_im_o;

  bfly_dif3m #(.DW(DW), .TW(TW), .TF(TF)) i_bfly_dif3m (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .w_re_i(w_re_i), .w_im_i(w_im_i),
    .valid_o(valid_o), .c_re_o(c_re_o), .c_im_o(c_im_o),
    .d_re_o(d_re_o), .d_im_o(d_im_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // index 2 is the sample due at the outputs now
  bit     hv[3];
  longint hc_re[3], hc_im[3], hd_re[3], hd_im[3];
  string  htag[3];
  longint last_c_re = 0, last_c_im = 0, last_d_re = 0, last_d_im = 0;

  function automatic longint rnd_q(longint x);
    return (x + (64'sd1 <<< (TF - 1))) >>> TF;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_out();
    if (hv[2]) begin
      chk(valid_o === 1'b1, "R2", "valid_o", longint'(valid_o), 1);
      chk(longint'(c_re_o) == hc_re[2], "R3", "c_re", longint'(c_re_o), hc_re[2]);
      chk(longint'(c_im_o) == hc_im[2], "R3", "c_im", longint'(c_im_o), hc_im[2]);
      chk(longint'(d_re_o) == hd_re[2], htag[2], "d_re", longint'(d_re_o), hd_re[2]);
      chk(longint'(d_im_o) == hd_im[2], htag[2], "d_im", longint'(d_im_o), hd_im[2]);
      last_c_re = hc_re[2]; last_c_im = hc_im[2];
      last_d_re = hd_re[2]; last_d_im = hd_im[2];
    end else begin
      chk(valid_o === 1'b0, "R2", "valid_o idle", longint'(valid_o), 0);
      chk(longint'(c_re_o) == last_c_re && longint'(c_im_o) == last_c_im, "R7", "c held",
          longint'(c_re_o), last_c_re);
      chk(longint'(d_re_o) == last_d_re && longint'(d_im_o) == last_d_im, "R7", "d held",
          longint'(d_re_o), last_d_re);
    end
  endtask

  task automatic step(bit v, longint ar, longint ai, longint br, longint bi,
                      longint wr, longint wi, string tag);
    longint dr, di, xr, xi, vr, vi;
    @(negedge clk);
    compare_out();
    valid_i = v;
    a_re_i = DW'(ar); a_im_i = DW'(ai); b_re_i = DW'(br); b_im_i = DW'(bi);
    w_re_i = TW'(wr); w_im_i = TW'(wi);
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hc_re[k] = hc_re[k-1]; hc_im[k] = hc_im[k-1];
      hd_re[k] = hd_re[k-1]; hd_im[k] = hd_im[k-1]; htag[k] = htag[k-1];
    end
    // four-multiplier reference
    dr = longint'(a_re_i) - longint'(b_re_i);
    di = longint'(a_im_i) - longint'(b_im_i);
    vr = longint'(w_re_i);
    vi = longint'(w_im_i);
    xr = dr * vr - di * vi;
    xi = dr * vi + di * vr;
    hv[0] = v;
    hc_re[0] = longint'(a_re_i) + longint'(b_re_i);
    hc_im[0] = longint'(a_im_i) + longint'(b_im_i);
    hd_re[0] = rnd_q(xr);
    hd_im[0] = rnd_q(xi);
    htag[0] = tag;
  endtask

  task automatic step_rand(bit v, string tag);
    step(v, longint'($urandom), longint'($urandom), longint'($urandom), longint'($urandom),
         longint'($urandom), longint'($urandom), tag);
  endtask

  localparam longint DMIN = -(64'sd1 <<< (DW - 1));
  localparam longint DMAX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint WMIN = -(64'sd1 <<< (TW - 1));
  localparam longint WMAX = (64'sd1 <<< (TW - 1)) - 1;
  localparam longint ONE  = 64'sd1 <<< TF;
  localparam longint HLF  = 64'sd1 <<< (TF - 1);

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      hv[k] = 0; hc_re[k] = 0; hc_im[k] = 0; hd_re[k] = 0; hd_im[k] = 0; htag[k] = "R7";
    end
    repeat (3) @(negedge clk);
    // R1: reset state, checked with reset still asserted and just after release
    chk(valid_o === 1'b0 && c_re_o == '0 && c_im_o == '0, "R1", "reset valid/c",
        longint'(valid_o), 0);
    chk(d_re_o == '0 && d_im_o == '0, "R1", "reset d", longint'(d_re_o), 0);
    rst_ni = 1'b1;
    #1;
    chk(valid_o === 1'b0 && d_re_o == '0 && c_re_o == '0, "R1", "after release",
        longint'(valid_o), 0);

    // R4 directed: zero and rounding ties
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, HLF, 0, "R4");
    step(1, -1, 0, 0, 0, HLF, 0, "R4");
    step(1, 3, -3, 0, 0, HLF, HLF, "R4");
    // R5 unity twiddle
    step(1, 1234, -77, -5000, 321, ONE, 0, "R5");
    step(1, DMIN, DMAX, DMAX, DMIN, ONE, 0, "R5");
    // R6 full-scale corners
    step(1, DMIN, DMIN, DMAX, DMAX, WMIN, WMIN, "R6");
    step(1, DMAX, DMIN, DMIN, DMAX, WMIN, WMAX, "R6");
    step(1, DMIN, DMIN, DMIN, DMIN, WMIN, WMIN, "R6");
    step(1, DMAX, DMAX, DMIN, DMIN, WMAX, WMIN, "R6");
    // R7 bubble with garbage data, then idle long enough to drain
    for (int k = 0; k < 5; k++) step_rand(0, "R7");
    // R8 back-to-back burst
    for (int k = 0; k < 8; k++) step_rand(1, "R8");
    // constrained random mix
    for (int k = 0; k < 3000; k++) step_rand(($urandom % 4) != 0, "R4");
    for (int k = 0; k < 4; k++) step_rand(0, "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule